// File: doc/BRIEF.md
# Simple-Mode Programmable Macrocell Array

This block is a small programmable-logic core in its simple operating mode. Eight macrocells sit around a programmable AND array. Each macrocell is either a dedicated input that feeds the array, or a combinational output that is always enabled. An output cell ORs eight product terms. It then applies a programmable polarity and drives its pad in either totem-pole or open-drain fashion.

The configuration is captured into registers on a load strobe and stays fixed during operation. The captured configuration is the global mode bit, four architecture bits per cell, and the AND-array fuse map. From that point the path from the pins to the pads is purely combinational.

Two dedicated data inputs always feed the array. The six outer cells feed the array through their pad-side input, whether they are set up as inputs or as outputs. When such a cell is an output, this input is the pad-level feedback. The two center cells are always outputs and feed nothing back.

Top module: `spl_array`

## Requirements
- R1: While reset is asserted, and after it is released with no configuration loaded, every pad_oe and pad_out bit is 0 and cfg_err is 0.
- R2: The configuration inputs (cfg_sync, cfg_ac0, cfg_ac1, cfg_ac2, cfg_pol, cfg_fuse) are captured on a rising clock edge where cfg_we is 1. Changes to them while cfg_we is 0 have no effect on the pads or on cfg_err.
- R3: A cell is active only when the loaded cfg_sync is 1 and that cell's cfg_ac0 is 0. An inactive cell has pad_oe = 0 and pad_out = 0.
- R4: The array signal vector is s = {ext_in, ded_in}: ded_in[0] is s0, ded_in[1] is s1, and ext_in[k] is s(k+2). Fuse bit (c*8 + t)*16 + 2*j selects the true form of sj for term t of cell c, and the next bit up selects the complement. A product term is the AND of its selected literals, and a term with no fuse set is 0.
- R5: The logic value of an output cell is the OR of its eight product terms when cfg_pol is 1, and the inverse of that OR when cfg_pol is 0.
- R6: An active output cell with cfg_ac2 = 1 drives pad_oe = 1 and pad_out = value. With cfg_ac2 = 0 it drives pad_out = 0 and pad_oe = NOT value, so it never drives a high level.
- R7: An active outer cell with cfg_ac1 = 1 is an input: its pad_oe and pad_out are 0.
- R8: The center cells (indices 3 and 4) stay outputs whatever their cfg_ac1 is. cfg_err is 1 exactly when the loaded cfg_ac1 of either center cell is 1.
- R9: The outer cells, in index order 0, 1, 2, 5, 6, 7, map to ext_in[0..5]. Each feeds the array in both the input and the output role.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration registers |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Load strobe for the configuration |
| cfg_sync | input | 1 | Global mode bit, must be 1 for simple mode |
| cfg_ac0 | input | 8 | Per-cell mode bit, must be 0 for simple mode |
| cfg_ac1 | input | 8 | Per-cell role: 1 input, 0 output |
| cfg_ac2 | input | 8 | Per-cell drive: 1 totem-pole, 0 open-drain |
| cfg_pol | input | 8 | Per-cell polarity: 1 active high, 0 active low |
| cfg_fuse | input | 1024 | AND-array fuse map |
| ded_in | input | 2 | Dedicated array inputs |
| ext_in | input | 6 | Pad-side inputs of the outer cells |
| pad_out | output | 8 | Pad data per cell |
| pad_oe | output | 8 | Pad enable per cell |
| cfg_err | output | 1 | A center cell was asked to be an input |

## Verification
Several kinds of fuse map are applied.
- Maps with a single literal, swept over every signal in both forms, show whether each fuse column reaches the right signal with the right sense.
- An empty map tells the "no literal means 0" rule apart from a term that is 1 when no literal is selected. This is done under both polarities.
- Random sparse maps with random architecture bits and all input patterns are compared against a sum-of-products model. They separate polarity, drive-mode and role mix-ups.
- Toggling the center-cell inputs and the unlatched configuration shows that neither reaches the pads.

// File: rtl/spl_pkg.sv
package spl_pkg;

  localparam int MAX_COL = 128;

  typedef enum logic [1:0] {CELL_OFF, CELL_IN, CELL_OUT} cell_mode_e;

  typedef struct packed {
    logic ac0;
    logic ac1;
    logic ac2;
    logic pol;
  } cell_cfg_t;

  // AND of the selected literals; an empty row yields 0
  function automatic logic pterm_eval(input logic [MAX_COL-1:0] lits,
                                      input logic [MAX_COL-1:0] row);
    return (|row) && ((lits & row) == row);
  endfunction

  function automatic cell_mode_e cell_mode(input logic active,
                                           input logic ac1,
                                           input logic center);
    if (!active)          return CELL_OFF;
    if (ac1 && !center)   return CELL_IN;
    return CELL_OUT;
  endfunction

  // returns {out, oe}
  function automatic logic [1:0] pad_drive(input cell_mode_e m,
                                           input logic val,
                                           input logic totem);
    if (m != CELL_OUT) return 2'b00;
    if (totem)         return {val, 1'b1};
    return {1'b0, ~val};
  endfunction

endpackage

// File: rtl/spl_cfg_regs.sv
module spl_cfg_regs
  import spl_pkg::*;
#(
  parameter int N_CELLS = 8,
  parameter int FUSE_W  = 1024
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      we,
  input  logic                      sync_d,
  input  cell_cfg_t [N_CELLS-1:0]   cell_d,
  input  logic [FUSE_W-1:0]         fuse_d,
  output logic                      sync_q,
  output cell_cfg_t [N_CELLS-1:0]   cell_q,
  output logic [FUSE_W-1:0]         fuse_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 1'b0;
      cell_q <= '0;
      fuse_q <= '0;
    end else if (we) begin
      sync_q <= sync_d;
      cell_q <= cell_d;
      fuse_q <= fuse_d;
    end
  end

endmodule

// File: rtl/spl_and_array.sv
module spl_and_array
  import spl_pkg::*;
#(
  parameter int N_CELLS = 8,
  parameter int N_TERMS = 8,
  parameter int N_DED   = 2,
  localparam int N_OUTER = N_CELLS - 2,
  localparam int N_SIG   = N_DED + N_OUTER,
  localparam int N_COL   = 2 * N_SIG,
  localparam int FUSE_W  = N_CELLS * N_TERMS * N_COL
) (
  input  logic [N_DED-1:0]           ded_in,
  input  logic [N_OUTER-1:0]         ext_in,
  input  logic [FUSE_W-1:0]          fuse,
  output logic [N_CELLS*N_TERMS-1:0] terms
);

  logic [N_SIG-1:0]   sig;
  logic [MAX_COL-1:0] lits;

  assign sig = {ext_in, ded_in};

  // each signal occupies two adjacent columns: true then complement
  for (genvar j = 0; j < N_SIG; j++) begin : g_lit
    assign lits[2*j]   = sig[j];
    assign lits[2*j+1] = ~sig[j];
  end
  if (MAX_COL > N_COL) begin : g_pad
    assign lits[MAX_COL-1:N_COL] = '0;
  end

  for (genvar r = 0; r < N_CELLS*N_TERMS; r++) begin : g_row
    logic [MAX_COL-1:0] row;
    assign row[N_COL-1:0] = fuse[r*N_COL +: N_COL];
    if (MAX_COL > N_COL) begin : g_rpad
      assign row[MAX_COL-1:N_COL] = '0;
    end
    assign terms[r] = pterm_eval(lits, row);
  end

endmodule

// File: rtl/spl_olmc.sv
module spl_olmc
  import spl_pkg::*;
#(
  parameter int N_TERMS   = 8,
  parameter bit IS_CENTER = 1'b0
) (
  input  logic               active,
  input  cell_cfg_t          cfg,
  input  logic [N_TERMS-1:0] terms,
  output logic               pad_out,
  output logic               pad_oe,
  output logic               cell_in,
  output logic               ac1_bad
);

  cell_mode_e mode;
  logic       sop;
  logic       value;
  logic [1:0] drv;

  assign sop     = |terms;
  assign value   = cfg.pol ? sop : ~sop;
  assign mode    = cell_mode(active, cfg.ac1, IS_CENTER);
  assign drv     = pad_drive(mode, value, cfg.ac2);
  assign pad_out = drv[1];
  assign pad_oe  = drv[0];
  assign cell_in = (mode == CELL_IN);
  assign ac1_bad = IS_CENTER && cfg.ac1;

endmodule

// File: rtl/spl_array.sv
module spl_array
  import spl_pkg::*;
#(
  parameter int N_CELLS = 8,
  parameter int N_TERMS = 8,
  parameter int N_DED   = 2,
  localparam int N_OUTER = N_CELLS - 2,
  localparam int FUSE_W  = N_CELLS * N_TERMS * 2 * (N_DED + N_OUTER)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic                cfg_sync,
  input  logic [N_CELLS-1:0]  cfg_ac0,
  input  logic [N_CELLS-1:0]  cfg_ac1,
  input  logic [N_CELLS-1:0]  cfg_ac2,
  input  logic [N_CELLS-1:0]  cfg_pol,
  input  logic [FUSE_W-1:0]   cfg_fuse,
  input  logic [N_DED-1:0]    ded_in,
  input  logic [N_OUTER-1:0]  ext_in,
  output logic [N_CELLS-1:0]  pad_out,
  output logic [N_CELLS-1:0]  pad_oe,
  output logic                cfg_err
);

  localparam int CTR_LO = N_CELLS / 2 - 1;
  localparam int CTR_HI = N_CELLS / 2;

  cell_cfg_t [N_CELLS-1:0]   cell_d;
  cell_cfg_t [N_CELLS-1:0]   cell_q;
  logic                      sync_q;
  logic [FUSE_W-1:0]         fuse_q;
  logic [N_CELLS*N_TERMS-1:0] terms;

  // named internal events for the checker
  logic [N_CELLS-1:0] active_w;
  logic [N_CELLS-1:0] cell_in_w;
  logic [N_CELLS-1:0] ac2_q;
  logic [N_CELLS-1:0] ac1_bad_w;

  for (genvar c = 0; c < N_CELLS; c++) begin : g_pack
    assign cell_d[c] = {cfg_ac0[c], cfg_ac1[c], cfg_ac2[c], cfg_pol[c]};
  end

  spl_cfg_regs #(.N_CELLS(N_CELLS), .FUSE_W(FUSE_W)) u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (cfg_we),
    .sync_d (cfg_sync),
    .cell_d (cell_d),
    .fuse_d (cfg_fuse),
    .sync_q (sync_q),
    .cell_q (cell_q),
    .fuse_q (fuse_q)
  );

  spl_and_array #(.N_CELLS(N_CELLS), .N_TERMS(N_TERMS), .N_DED(N_DED)) u_arr (
    .ded_in (ded_in),
    .ext_in (ext_in),
    .fuse   (fuse_q),
    .terms  (terms)
  );

  for (genvar c = 0; c < N_CELLS; c++) begin : g_cell
    assign active_w[c] = sync_q && !cell_q[c].ac0;
    assign ac2_q[c]    = cell_q[c].ac2;
    spl_olmc #(
      .N_TERMS   (N_TERMS),
      .IS_CENTER ((c == CTR_LO) || (c == CTR_HI))
    ) u_mc (
      .active  (active_w[c]),
      .cfg     (cell_q[c]),
      .terms   (terms[c*N_TERMS +: N_TERMS]),
      .pad_out (pad_out[c]),
      .pad_oe  (pad_oe[c]),
      .cell_in (cell_in_w[c]),
      .ac1_bad (ac1_bad_w[c])
    );
  end

  assign cfg_err = |ac1_bad_w;

endmodule

module spl_array_chk #(
  parameter int N_CELLS = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cfg_we,
  input logic [N_CELLS-1:0] active_w,
  input logic [N_CELLS-1:0] cell_in_w,
  input logic [N_CELLS-1:0] ac2_q,
  input logic [N_CELLS-1:0] pad_out,
  input logic [N_CELLS-1:0] pad_oe,
  input logic               cfg_err
);

  for (genvar c = 0; c < N_CELLS; c++) begin : g_chk
    a_r3_inactive_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !active_w[c] |-> (!pad_oe[c] && !pad_out[c]));
    a_r6_totem_enabled: assert property (@(posedge clk) disable iff (!rst_n)
      (active_w[c] && !cell_in_w[c] && ac2_q[c]) |-> pad_oe[c]);
    a_r6_open_drain_low: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_oe[c] && !ac2_q[c]) |-> !pad_out[c]);
    a_r7_input_released: assert property (@(posedge clk) disable iff (!rst_n)
      cell_in_w[c] |-> (!pad_oe[c] && !pad_out[c]));
    if ((c == N_CELLS/2 - 1) || (c == N_CELLS/2)) begin : g_ctr
      a_r8_center_output: assert property (@(posedge clk) disable iff (!rst_n)
        !cell_in_w[c]);
    end
  end

  a_r2_err_on_load: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_err) |-> $past(cfg_we));

endmodule

bind spl_array spl_array_chk #(.N_CELLS(N_CELLS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_we    (cfg_we),
  .active_w  (active_w),
  .cell_in_w (cell_in_w),
  .ac2_q     (ac2_q),
  .pad_out   (pad_out),
  .pad_oe    (pad_oe),
  .cfg_err   (cfg_err)
);

// File: tb/spl_array_test.sv
`timescale 1ns/1ps
module spl_array_test;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic          cfg_sync = 1'b0;
  logic [7:0]    cfg_ac0 = '0, cfg_ac1 = '0, cfg_ac2 = '0, cfg_pol = '0;
  logic [1023:0] cfg_fuse = '0;
  logic [1:0]    ded_in = '0;
  logic [5:0]    ext_in = '0;
  logic [7:0]    pad_out, pad_oe;
  logic          cfg_err;

  // bench copy of the loaded configuration
  logic          m_sync;
  logic [7:0]    m_ac0, m_ac1, m_ac2, m_pol;
  logic [1023:0] m_fuse;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  spl_array uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sync(cfg_sync),
    .cfg_ac0(cfg_ac0), .cfg_ac1(cfg_ac1), .cfg_ac2(cfg_ac2), .cfg_pol(cfg_pol),
    .cfg_fuse(cfg_fuse), .ded_in(ded_in), .ext_in(ext_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .cfg_err(cfg_err)
  );

  task automatic check(input string req, input logic [16:0] act, input logic [16:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got out/oe/err=%h expected %h", req, act, exp);
    end
  endtask

  // independent sum-of-products reference
  task automatic model(output logic [7:0] eo, output logic [7:0] eoe, output logic eerr);
    logic [7:0] s;
    s = {ext_in, ded_in};
    for (int c = 0; c < 8; c++) begin
      logic sop, val, act, inp, ctr;
      sop = 1'b0;
      for (int t = 0; t < 8; t++) begin
        logic any, v;
        any = 1'b0; v = 1'b1;
        for (int j = 0; j < 8; j++) begin
          int b;
          b = (c*8 + t)*16 + 2*j;
          if (m_fuse[b])   begin any = 1'b1; v = v & s[j];  end
          if (m_fuse[b+1]) begin any = 1'b1; v = v & ~s[j]; end
        end
        sop = sop | (any & v);
      end
      val = m_pol[c] ? sop : ~sop;
      ctr = (c == 3) || (c == 4);
      act = m_sync && !m_ac0[c];
      inp = m_ac1[c] && !ctr;
      if (!act || inp) begin eo[c] = 1'b0; eoe[c] = 1'b0; end
      else if (m_ac2[c]) begin eo[c] = val; eoe[c] = 1'b1; end
      else begin eo[c] = 1'b0; eoe[c] = ~val; end
    end
    eerr = m_ac1[3] | m_ac1[4];
  endtask

  task automatic compare(input string req);
    logic [7:0] eo, eoe; logic ee;
    #1;
    model(eo, eoe, ee);
    check(req, {pad_out, pad_oe, cfg_err}, {eo, eoe, ee});
  endtask

  task automatic load();
    @(negedge clk);
    cfg_sync = m_sync; cfg_ac0 = m_ac0; cfg_ac1 = m_ac1;
    cfg_ac2 = m_ac2; cfg_pol = m_pol; cfg_fuse = m_fuse; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rand_fuse();
    m_fuse = '0;
    for (int r = 0; r < 64; r++) begin
      if ($urandom % 4 != 0) begin
        for (int j = 0; j < 8; j++) begin
          int k;
          k = $urandom % 5;
          if (k == 1) m_fuse[r*16 + 2*j] = 1'b1;
          if (k == 2) m_fuse[r*16 + 2*j + 1] = 1'b1;
        end
      end
    end
  endtask

  task automatic t_reset();
    #1;
    check("R1 in reset", {pad_out, pad_oe, cfg_err}, 17'd0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #1;
    check("R1 after reset", {pad_out, pad_oe, cfg_err}, 17'd0);
  endtask

  task automatic t_empty();
    m_sync = 1'b1; m_ac0 = '0; m_ac1 = '0; m_ac2 = '1; m_fuse = '0;
    m_pol = '0; load();
    ded_in = 2'b11; ext_in = 6'h3f; #1;
    check("R4 empty term pol0", {pad_out, pad_oe, cfg_err}, {8'hff, 8'hff, 1'b0});
    m_pol = '1; load(); #1;
    check("R4 empty term pol1", {pad_out, pad_oe, cfg_err}, {8'h00, 8'hff, 1'b0});
  endtask

  task automatic t_literal();
    m_sync = 1'b1; m_ac0 = '0; m_ac1 = '0; m_ac2 = '1; m_pol = '1;
    for (int j = 0; j < 8; j++) begin
      for (int cmp = 0; cmp < 2; cmp++) begin
        m_fuse = '0;
        m_fuse[(0*8 + 5)*16 + 2*j + cmp] = 1'b1;   // cell 0, term 5
        load();
        for (int v = 0; v < 2; v++) begin
          logic [7:0] s;
          s = (v != 0) ? (8'h01 << j) : ~(8'h01 << j);
          ded_in = s[1:0]; ext_in = s[7:2]; #1;
          check("R4 single literal", {7'd0, pad_out[0]},
                {7'd0, (cmp == 0) ? v[0] : ~v[0]});
          compare("R9 literal model");
        end
      end
    end
  endtask

  task automatic t_inactive();
    rand_fuse(); m_ac1 = '0; m_ac2 = '1; m_pol = 8'h5a; m_ac0 = '0;
    m_sync = 1'b0; load();
    ded_in = 2'b01; ext_in = 6'h2b;
    check("R3 sync low", {pad_out, pad_oe}, 16'd0);
    compare("R3 sync low model");
    m_sync = 1'b1; m_ac0 = 8'b1001_0110; load();
    for (int p = 0; p < 8; p++) begin
      {ded_in, ext_in} = 8'(p * 37);
      compare("R3 per-cell ac0");
    end
  endtask

  task automatic t_hold();
    m_sync = 1'b1; m_ac0 = '0; m_ac1 = 8'h01; m_ac2 = 8'hf0; m_pol = 8'h3c;
    rand_fuse(); load();
    ded_in = 2'b10; ext_in = 6'h15;
    compare("R2 loaded");
    @(negedge clk);
    cfg_sync = 1'b0; cfg_ac0 = '1; cfg_ac1 = '1; cfg_ac2 = ~m_ac2;
    cfg_pol = ~m_pol; cfg_fuse = ~m_fuse;
    repeat (3) @(negedge clk);
    compare("R2 no load no effect");
  endtask

  task automatic t_center();
    m_sync = 1'b1; m_ac0 = '0; m_ac1 = '1; m_ac2 = '1; m_pol = '1; m_fuse = '0;
    m_fuse[(3*8)*16 + 0] = 1'b1;          // cell 3 term 0: ded_in[0]
    m_fuse[(4*8)*16 + 2*2 + 1] = 1'b1;    // cell 4 term 0: ~ext_in[0]
    load();
    for (int p = 0; p < 4; p++) begin
      ded_in = p[1:0]; ext_in = {5'd0, p[1]}; #1;
      check("R8 center stays output", {pad_out[4:3], pad_oe[4:3], cfg_err, 12'd0},
            {~p[1], p[0], 2'b11, 1'b1, 12'd0});
      check("R7 outer inputs released", {9'd0, pad_oe[7:5], pad_oe[2:0]}, 17'd0);
      compare("R9 ext feeds array");
    end
    m_ac1 = 8'b1110_0111; load(); compare("R8 err clear");
  endtask

  task automatic t_random();
    for (int n = 0; n < 40; n++) begin
      rand_fuse();
      m_sync = 1'b1;
      m_ac0 = ($urandom % 4 == 0) ? 8'($urandom) : 8'h00;
      m_ac1 = 8'($urandom); m_ac2 = 8'($urandom); m_pol = 8'($urandom);
      load();
      for (int p = 0; p < 16; p++) begin
        {ded_in, ext_in} = 8'($urandom);
        compare((p % 2 == 0) ? "R5 random sop" : "R6 random drive");
      end
    end
  endtask

  initial begin
    m_sync = 0; m_ac0 = 0; m_ac1 = 0; m_ac2 = 0; m_pol = 0; m_fuse = '0;
    void'($urandom(7));
    t_reset();
    t_empty();
    t_literal();
    t_inactive();
    t_hold();
    t_center();
    t_random();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1;
      n_vec++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule